// File: doc/BRIEF.md
# Restartable Load/Store-Multiple Sequencer

This block is the execute-stage engine for block transfers between a register file and memory: loading several registers from consecutive words, storing several registers to them, and the push/pop forms of the same. It is started with a base address, a bitmask of the registers to move, a direction and a write-back flag. It then drives one data-bus beat per selected register through a single memory port. Registers go in ascending register-number order, and the address steps by 4 on each beat.

Interrupt latency is kept short because the block gives up part-way. When an interrupt is pending at the end of any beat except the last, the sequencer drops the instruction and frees the bus for exception stacking. Words already loaded sit in a private staging buffer, and the base write-back has not been made. The register file therefore still holds its state from before the instruction, and the instruction can be issued again later from its first beat. On the rerun the same addresses are accessed again. Register updates (loaded values and the new base) are presented for one cycle, only when the instruction finishes.

Top module: `lsm_seq`

## Requirements
- R1: A transfer holds `busy` high and issues exactly one beat per set bit of the register mask. The beats go in ascending register number, beat k going to address base+4k. `bus_we` is 1 for a store and 0 for a load. On a store, `bus_wdata` is the value of the register being sent.
- R2: Once a beat is driven (`bus_req`=1), it keeps the same address and direction until `bus_ready` is seen. An interrupt never ends a beat early.
- R3: When `irq_pend` is high in the cycle in which a non-final beat completes, the instruction is abandoned. `abandoned` is high for exactly one cycle, and in that cycle `bus_req` and `busy` are already low.
- R4: When `irq_pend` is high as the final beat completes, the instruction completes normally with `done`.
- R5: An abandoned instruction makes no architectural update: `commit_mask` is 0 and `wb_we` is 0.
- R6: On completion, `done` is high for one cycle. For a load, in that cycle `commit_mask` equals the register mask and slot r of `commit_data` (bits r*DW upward) holds the word read for register r. For a store, `commit_mask` is 0.
- R7: On completion with the write-back flag set, `wb_we` is high and `wb_addr` = base + 4 × (number of listed registers). With the flag clear, `wb_we` stays 0.
- R8: An empty register mask gives `done` in the cycle after `start`, and `bus_req` is never raised.
- R9: An instruction issued again after an abandon repeats every beat from the first one, to the same addresses.
- R10: `start` is ignored while `busy` is high.
- R11: After reset, `busy`, `done`, `abandoned`, `bus_req`, `wb_we` and `commit_mask` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an instruction (taken only when idle) |
| base_addr | input | AW | Address of the first beat |
| reg_list | input | NREG | Mask of registers to transfer |
| is_load | input | 1 | 1 = load from memory, 0 = store to memory |
| wb_en | input | 1 | Write the updated base back on completion |
| irq_pend | input | 1 | Interrupt pending |
| bus_req | output | 1 | Beat valid on the data bus |
| bus_we | output | 1 | Beat is a write |
| bus_addr | output | AW | Beat address |
| bus_wdata | output | DW | Store data |
| bus_ready | input | 1 | Beat completes this cycle |
| bus_rdata | input | DW | Load data, valid with `bus_ready` |
| rf_rd_idx | output | log2(NREG) | Register read for the store beat |
| rf_rd_data | input | DW | Value of register `rf_rd_idx` |
| commit_mask | output | NREG | Registers to write this cycle |
| commit_data | output | NREG*DW | Loaded values, one slot per register |
| wb_we | output | 1 | Write the updated base register |
| wb_addr | output | AW | Updated base value |
| done | output | 1 | Instruction completed (one cycle) |
| abandoned | output | 1 | Instruction dropped for an interrupt (one cycle) |
| busy | output | 1 | Transfer in progress |

## Verification
The bench builds the sequencer with four registers and 16-bit addresses and data. With that setting it can run every one of the 16 register masks, in both directions, with and without write-back. For each of these it tries an interrupt at every possible beat position as well as no interrupt. Bus stalls of zero to two cycles, which vary from beat to beat, exercise how beats are held. Every abandoned run is issued a second time so that the repeated addresses can be compared.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } seq_state_e;

    localparam int unsigned BEAT_BYTES = 4;

endpackage

// File: rtl/lsm_pick.sv
module lsm_pick #(
    parameter int NREG = 8,
    localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic [NREG-1:0] mask,
    output logic [NREG-1:0] onehot,
    output logic [IW-1:0]   idx,
    output logic            valid,
    output logic            last
);

    // lowest set bit is the next register to move
    assign onehot = mask & (~mask + NREG'(1));
    assign valid  = |mask;
    assign last   = valid && ((mask & (mask - NREG'(1))) == '0);

    always_comb begin
        idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (mask[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/lsm_stage.sv
module lsm_stage #(
    parameter int NREG = 8,
    parameter int DW   = 32,
    localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [IW-1:0]      idx,
    input  logic [DW-1:0]      wdata,
    output logic [NREG*DW-1:0] data_flat
);

    logic [DW-1:0] slot_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (we && (idx == IW'(g))) begin
                slot_q[g] <= wdata;
            end
        end
        assign data_flat[g*DW +: DW] = slot_q[g];
    end

endmodule

// File: rtl/lsm_seq.sv
module lsm_seq #(
    parameter int NREG = 8,
    parameter int AW   = 32,
    parameter int DW   = 32,
    localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [AW-1:0]      base_addr,
    input  logic [NREG-1:0]    reg_list,
    input  logic               is_load,
    input  logic               wb_en,
    input  logic               irq_pend,
    output logic               bus_req,
    output logic               bus_we,
    output logic [AW-1:0]      bus_addr,
    output logic [DW-1:0]      bus_wdata,
    input  logic               bus_ready,
    input  logic [DW-1:0]      bus_rdata,
    output logic [IW-1:0]      rf_rd_idx,
    input  logic [DW-1:0]      rf_rd_data,
    output logic [NREG-1:0]    commit_mask,
    output logic [NREG*DW-1:0] commit_data,
    output logic               wb_we,
    output logic [AW-1:0]      wb_addr,
    output logic               done,
    output logic               abandoned,
    output logic               busy
);
    import lsm_pkg::*;

    localparam logic [AW-1:0] STEP = AW'(BEAT_BYTES);

    typedef struct packed {
        seq_state_e      st;
        logic [NREG-1:0] list;
        logic [NREG-1:0] rem;
        logic [AW-1:0]   base;
        logic [AW-1:0]   addr;
        logic            load;
        logic            wb;
        logic            done;
        logic            abandoned;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [NREG-1:0] pick_oh;
    logic [IW-1:0]   pick_idx;
    logic            pick_valid;
    logic            pick_last;
    logic            beat_fire;

    lsm_pick #(.NREG(NREG)) u_pick (
        .mask   (seq_q.rem),
        .onehot (pick_oh),
        .idx    (pick_idx),
        .valid  (pick_valid),
        .last   (pick_last)
    );

    assign beat_fire = (seq_q.st == ST_XFER) && pick_valid && bus_ready;

    lsm_stage #(.NREG(NREG), .DW(DW)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (beat_fire && seq_q.load),
        .idx       (pick_idx),
        .wdata     (bus_rdata),
        .data_flat (commit_data)
    );

    always_comb begin
        seq_d           = seq_q;
        seq_d.done      = 1'b0;
        seq_d.abandoned = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    seq_d.list = reg_list;
                    seq_d.rem  = reg_list;
                    seq_d.base = base_addr;
                    seq_d.addr = base_addr;
                    seq_d.load = is_load;
                    seq_d.wb   = wb_en;
                    if (reg_list == '0) seq_d.done = 1'b1;
                    else                seq_d.st   = ST_XFER;
                end
            end
            ST_XFER: begin
                if (beat_fire) begin
                    seq_d.rem = seq_q.rem & ~pick_oh;
                    if (pick_last) begin
                        seq_d.st   = ST_IDLE;
                        seq_d.done = 1'b1;
                    end else if (irq_pend) begin
                        seq_d.st        = ST_IDLE;
                        seq_d.abandoned = 1'b1;
                    end else begin
                        seq_d.addr = seq_q.addr + STEP;
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy        = (seq_q.st == ST_XFER);
    assign bus_req     = busy;
    assign bus_we      = busy && !seq_q.load;
    assign bus_addr    = seq_q.addr;
    assign bus_wdata   = rf_rd_data;
    assign rf_rd_idx   = pick_idx;
    assign done        = seq_q.done;
    assign abandoned   = seq_q.abandoned;
    assign commit_mask = (seq_q.done && seq_q.load) ? seq_q.list : '0;
    assign wb_we       = seq_q.done && seq_q.wb;
    assign wb_addr     = seq_q.base + (AW'($countones(seq_q.list)) << 2);

endmodule

// File: rtl/lsm_seq_chk.sv
module lsm_seq_chk #(
    parameter int NREG = 8,
    parameter int AW   = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            irq_pend,
    input logic            bus_req,
    input logic            bus_we,
    input logic [AW-1:0]   bus_addr,
    input logic            bus_ready,
    input logic [NREG-1:0] commit_mask,
    input logic            wb_we,
    input logic            done,
    input logic            abandoned,
    input logic            busy
);

    assert_beat_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

    assert_abandon_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        abandoned |=> !abandoned);

    assert_abandon_needs_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        abandoned |-> ($past(irq_pend) && $past(bus_ready) && !bus_req && !busy));

    assert_no_commit_on_abandon_R5: assert property (@(posedge clk) disable iff (!rst_n)
        abandoned |-> (commit_mask == '0 && !wb_we && !done));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_commit_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((commit_mask != '0) || wb_we) |-> done);

    assert_start_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy || done));

endmodule

bind lsm_seq lsm_seq_chk #(.NREG(NREG), .AW(AW)) u_lsm_seq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .irq_pend    (irq_pend),
    .bus_req     (bus_req),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_ready   (bus_ready),
    .commit_mask (commit_mask),
    .wb_we       (wb_we),
    .done        (done),
    .abandoned   (abandoned),
    .busy        (busy)
);

// File: tb/lsm_seq_test.sv
module lsm_seq_test;

    localparam int NREG = 4;
    localparam int AW   = 16;
    localparam int DW   = 16;
    localparam int IW   = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [AW-1:0]      base_addr = '0;
    logic [NREG-1:0]    reg_list = '0;
    logic               is_load = 1'b0;
    logic               wb_en = 1'b0;
    logic               irq_pend = 1'b0;
    logic               bus_req, bus_we;
    logic [AW-1:0]      bus_addr;
    logic [DW-1:0]      bus_wdata;
    logic               bus_ready = 1'b0;
    logic [DW-1:0]      bus_rdata = '0;
    logic [IW-1:0]      rf_rd_idx;
    logic [DW-1:0]      rf_rd_data;
    logic [NREG-1:0]    commit_mask;
    logic [NREG*DW-1:0] commit_data;
    logic               wb_we;
    logic [AW-1:0]      wb_addr;
    logic               done, abandoned, busy;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    function automatic logic [DW-1:0] rf_val(input int r);
        return DW'(16'h1000 + r * 16'h0111);
    endfunction

    function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
        return a ^ 16'h5A3C;
    endfunction

    assign rf_rd_data = rf_val(int'(rf_rd_idx));

    lsm_seq #(.NREG(NREG), .AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .reg_list(reg_list), .is_load(is_load), .wb_en(wb_en), .irq_pend(irq_pend),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata), .rf_rd_idx(rf_rd_idx),
        .rf_rd_data(rf_rd_data), .commit_mask(commit_mask), .commit_data(commit_data),
        .wb_we(wb_we), .wb_addr(wb_addr), .done(done), .abandoned(abandoned), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [NREG-1:0] lst, input bit ld, input bit wb,
                          input int irq_at, input logic [AW-1:0] base,
                          input string areq, output bit was_abandoned);
        int n;
        int regs[NREG];
        int k;
        int stall;
        int cyc;
        bit fin;
        bit exp_ab;
        n = 0;
        for (int r = 0; r < NREG; r++) if (lst[r]) begin regs[n] = r; n++; end
        exp_ab = (irq_at >= 0) && (irq_at < n - 1);
        was_abandoned = 1'b0;
        @(negedge clk);
        start = 1'b1; base_addr = base; reg_list = lst; is_load = ld; wb_en = wb;
        irq_pend = 1'b0; bus_ready = 1'b0;
        @(negedge clk);
        if (n > 0) begin
            // R10: a second start with different arguments while busy
            base_addr = base ^ 16'hFF00; reg_list = ~lst; is_load = ~ld;
        end else begin
            start = 1'b0;
        end
        k = 0; stall = int'(lst) % 3; cyc = 0; fin = 1'b0;
        while (!fin && cyc < 60) begin
            cyc++;
            if (done || abandoned) begin
                fin = 1'b1;
            end else begin
                check(busy == 1'b1 && bus_req == 1'b1, "R1", {busy, bus_req}, 2'b11);
                if (k < n) begin
                    check(bus_addr == base + AW'(4 * k), areq, bus_addr, base + AW'(4 * k));
                    check(bus_we == !ld, "R1", bus_we, !ld);
                    if (!ld) check(bus_wdata == rf_val(regs[k]), "R1", bus_wdata, rf_val(regs[k]));
                end else begin
                    check(1'b0, "R1", k, n);
                end
                irq_pend = (irq_at >= 0) && (k >= irq_at);
                if (stall > 0) begin
                    bus_ready = 1'b0;
                    stall--;
                end else begin
                    bus_ready = 1'b1;
                    bus_rdata = mem_val(bus_addr);
                end
                @(negedge clk);
                start = 1'b0;
                if (bus_ready) begin
                    k++;
                    stall = (k + int'(lst)) % 3;
                end
                bus_ready = 1'b0;
            end
        end
        irq_pend = 1'b0;
        check(fin, "R1", cyc, 60);
        if (n == 0) check(k == 0 && done && cyc == 1, "R8", {k[3:0], done}, 1);
        if (exp_ab) begin
            check(abandoned && !done, "R3", {abandoned, done}, 2'b10);
            check(k == irq_at + 1, "R3", k, irq_at + 1);
            check(!bus_req && !busy, "R3", {bus_req, busy}, 0);
            check(commit_mask == '0 && !wb_we, "R5", {commit_mask, wb_we}, 0);
            was_abandoned = abandoned;
        end else begin
            check(done && !abandoned, (irq_at >= 0) ? "R4" : "R6", {done, abandoned}, 2'b10);
            check(k == n, "R1", k, n);
            check(commit_mask == (ld ? lst : '0), "R6", commit_mask, ld ? lst : '0);
            if (ld) begin
                for (int j = 0; j < n; j++) begin
                    check(commit_data[regs[j]*DW +: DW] == mem_val(base + AW'(4 * j)), "R6",
                          commit_data[regs[j]*DW +: DW], mem_val(base + AW'(4 * j)));
                end
            end
            check(wb_we == wb, "R7", wb_we, wb);
            if (wb) check(wb_addr == base + AW'(4 * n), "R7", wb_addr, base + AW'(4 * n));
            check(!bus_req, "R8", bus_req, 0);
        end
        @(negedge clk);
        check(!done && !abandoned && !busy, "R6", {done, abandoned, busy}, 0);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        bit ab;
        bit dummy;
        repeat (3) @(negedge clk);
        check(!busy && !done && !abandoned && !bus_req && !wb_we && commit_mask == '0,
              "R11", {busy, done, abandoned, bus_req, wb_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !bus_req, "R11", {busy, done, bus_req}, 0);
        for (int l = 0; l < 16; l++) begin
            for (int d = 0; d < 2; d++) begin
                for (int w = 0; w < 2; w++) begin
                    for (int q = -1; q < $countones(l[3:0]); q++) begin
                        logic [AW-1:0] b;
                        b = AW'(16'h0100 + l * 16'h0040 + d * 16'h0800 + w * 16'h2000);
                        run_op(l[3:0], d[0], w[0], q, b, "R1", ab);
                        if (ab) run_op(l[3:0], d[0], w[0], -1, b, "R9", dummy);
                    end
                end
            end
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule